// File: doc/BRIEF.md
# Buffered 9-bit UART Transmitter

This block is the asynchronous transmit half of a serial port. Software places a character in a one-deep holding register. When the shifter is free, the character moves into the shift register on the next bit-rate tick. The line then carries a low start bit, the data bits least significant first, an optional ninth bit and a high stop bit. Each bit lasts one tick interval. Because of the holding register, the host can queue the next character while the current one is on the line, so frames follow each other with no idle gap.

The ninth bit does not come from the holding register. It is taken from a separate control input at the moment the character is loaded. Two status outputs report state: one says the holding register is free and feeds the interrupt line through an enable, and the other says the shifter has finished. A transmit enable and a port enable must both be high for anything to be sent. Dropping either one abandons the frame in progress and returns the line to its high idle level.

Top module: `uart_tx9`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `shift_empty` is 1 and, with `irq_en` low, `irq` is 0.
- R2: A cycle with `wr_stb` high stores `wr_data` in the holding register, and `hold_empty` reads 0 from the next cycle on. A write to a full holding register replaces its contents.
- R3: A character moves from the holding register to the shifter only in a cycle with `tick` high. The shifter must be idle or be ending its stop bit in that cycle. The same load returns `hold_empty` to 1.
- R4: A frame is a start bit of 0, then the data bits starting with bit 0, then a stop bit of 1. `txd` changes in the cycle after a `tick`, so each bit lasts one tick interval.
- R5: With `nine_bit_en` high at load time, one extra bit is sent after the data bits and before the stop bit. Its value is `bit9_val` sampled at load time. With `nine_bit_en` low, the stop bit follows the data bits directly.
- R6: If the holding register is full when a stop bit ends, the next start bit begins at that same tick, with no idle tick between the frames.
- R7: `shift_empty` is 1 exactly when no frame is in progress, and `txd` is 1 whenever `shift_empty` is 1.
- R8: `irq` equals `irq_en` AND `hold_empty`.
- R9: While `tx_en` is 0, no frame starts and `txd` stays 1. A character written meanwhile waits in the holding register and is sent once `tx_en` returns to 1.
- R10: Dropping `port_en` aborts a frame in progress. From the next cycle `txd` is 1 and `shift_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable; low aborts and idles the line |
| tx_en | input | 1 | Transmit enable |
| nine_bit_en | input | 1 | Selects 9 data bits when high |
| bit9_val | input | 1 | Value of the ninth bit, sampled at load |
| irq_en | input | 1 | Interrupt enable |
| tick | input | 1 | One-cycle bit-rate pulse |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register free |
| shift_empty | output | 1 | No frame in progress |
| irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume that `tick` is a single-cycle pulse generated synchronously to `clk`, and that `nine_bit_en` and `bit9_val` are steady when a load happens. The stimulus respects both. It produces `tick` as one high cycle every eighth cycle, and it sets the width and ninth-bit controls before a write, keeping them until the holding register has emptied. Writes are made only after `hold_empty` has been seen high, apart from the deliberate tests with the enables low. A scoreboard queue of expected frames is matched bit by bit against the line, sampled one cycle after each tick.

// File: rtl/uart_tx9.sv
module uart_tx9 #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              nine_bit_en,
  input  logic              bit9_val,
  input  logic              irq_en,
  input  logic              tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);

  localparam int SH_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 4);
  localparam logic [CNT_W-1:0] LEN9 = CNT_W'(DATA_W + 3);
  localparam logic [CNT_W-1:0] LEN8 = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              txd_q;

  wire active = port_en & tx_en;
  wire load   = active & tick & hold_full & (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (load) hold_full <= 1'b0;
      if (wr_stb) begin
        hold_full <= 1'b1;
        hold_q    <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      txd_q <= 1'b1;
    end else if (!active) begin
      cnt_q <= '0;
      txd_q <= 1'b1;
    end else if (load) begin
      txd_q <= 1'b0;
      sh_q  <= {1'b1, nine_bit_en ? bit9_val : 1'b1, hold_q};
      cnt_q <= nine_bit_en ? LEN9 : LEN8;
    end else if (tick && cnt_q > ONE) begin
      txd_q <= sh_q[0];
      sh_q  <= {1'b1, sh_q[SH_W-1:1]};
      cnt_q <= cnt_q - ONE;
    end else if (tick && cnt_q == ONE) begin
      cnt_q <= '0;
    end
  end

  assign txd         = txd_q;
  assign hold_empty  = ~hold_full;
  assign shift_empty = (cnt_q == '0);
  assign irq         = irq_en & hold_empty;

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);

  // R3
  load_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> $past(tick));

  // R3
  hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(tick) && !shift_empty);

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !txd);

  // R2
  wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !hold_empty);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> txd && shift_empty);

  // R9
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd && shift_empty);

endmodule

// File: tb/uart_tx9_tb.sv
module uart_tx9_tb;
  localparam int DW = 8;

  typedef struct {
    logic [DW-1:0] data;
    logic          nine;
    logic          b9;
    logic          gap0;
  } frame_t;

  logic clk = 0, rst_n = 0;
  logic port_en = 0, tx_en = 0, nine_bit_en = 0, bit9_val = 0, irq_en = 0;
  logic tick = 0, wr_stb = 0;
  logic [DW-1:0] wr_data = '0;
  logic txd, hold_empty, shift_empty, irq;

  int checks = 0, errors = 0, cycles = 0;
  bit tick_run = 0, mon_busy = 0, done = 0;
  frame_t exp_q[$];

  always #5 clk = ~clk;

  uart_tx9 #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
    .nine_bit_en(nine_bit_en), .bit9_val(bit9_val), .irq_en(irq_en),
    .tick(tick), .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 8;
      tick = tick_run && (div == 0);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        check(0, "watchdog", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // monitor: samples the line one step after each tick edge
  initial begin
    frame_t cur;
    int pos = 0, idle = 0;
    logic [DW-1:0] got = '0;
    cur = '{default: '0};
    forever begin
      bit t, en;
      @(posedge clk);
      t = tick;
      en = port_en && tx_en;
      #2;
      if (!en) begin mon_busy = 0; continue; end
      if (!t) continue;
      if (!mon_busy) begin
        if (txd == 1'b0) begin
          if (exp_q.size() == 0) check(0, "R4 unexpected start", 0, 1);
          else begin
            cur = exp_q.pop_front();
            if (cur.gap0) check(idle == 0, "R6 idle ticks between frames", idle, 0);
          end
          mon_busy = 1; pos = 0; got = '0;
        end else idle++;
      end else begin
        pos++;
        if (pos <= DW) got[pos-1] = txd;
        else if (cur.nine && pos == DW + 1)
          check(txd == cur.b9, "R5 ninth bit", int'(txd), int'(cur.b9));
        else begin
          check(got == cur.data, "R4 data bits", int'(got), int'(cur.data));
          check(txd == 1'b1, "R4 stop bit", int'(txd), 1);
          mon_busy = 0; idle = 0;
        end
      end
    end
  end

  task automatic write(input logic [DW-1:0] d, input bit gap0);
    @(negedge clk);
    wr_stb = 1; wr_data = d;
    exp_q.push_back('{data: d, nine: nine_bit_en, b9: bit9_val, gap0: gap0});
    @(posedge clk); #1;
    check(!hold_empty, "R2 hold_empty after write", int'(hold_empty), 0);
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic wait_hold_empty;
    do @(negedge clk); while (!hold_empty);
  endtask

  task automatic wait_idle;
    do @(negedge clk);
    while (!(exp_q.size() == 0 && !mon_busy && shift_empty && hold_empty));
    check(txd == 1'b1, "R7 line high when idle", int'(txd), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1 && hold_empty == 1 && shift_empty == 1 && irq == 0,
          "R1 reset state", {txd, hold_empty, shift_empty, irq}, 4'b1110);
    rst_n = 1;
    @(negedge clk);
    port_en = 1; tx_en = 1; irq_en = 1; tick_run = 1;
    #1 check(irq == 1, "R8 irq with empty holding", int'(irq), 1);

    write(8'hA5, 0);
    #1 check(irq == 0, "R8 irq while holding full", int'(irq), 0);
    wait_idle();

    nine_bit_en = 1; bit9_val = 1;
    write(8'h3C, 0); wait_idle();
    bit9_val = 0;
    write(8'hC3, 0); wait_idle();

    nine_bit_en = 0;
    write(8'h01, 0); wait_hold_empty();
    check(!shift_empty, "R3 shifter busy after load", int'(shift_empty), 0);
    write(8'h80, 1); wait_hold_empty();
    write(8'hFF, 1); wait_idle();

    nine_bit_en = 1; bit9_val = 1;
    write(8'h55, 0); wait_hold_empty();
    write(8'hAA, 1); wait_idle();
    nine_bit_en = 0; bit9_val = 0;

    tx_en = 0;
    write(8'h5A, 0);
    repeat (40) @(negedge clk);
    check(txd == 1 && shift_empty == 1, "R9 nothing sent while tx off",
          {txd, shift_empty}, 2'b11);
    check(hold_empty == 0, "R9 character held", int'(hold_empty), 0);
    tx_en = 1;
    wait_idle();

    write(8'h00, 0);
    do @(negedge clk); while (shift_empty);
    repeat (20) @(negedge clk);
    port_en = 0;
    @(posedge clk); #1;
    check(txd == 1 && shift_empty == 1, "R10 abort idles line",
          {txd, shift_empty}, 2'b11);
    repeat (3) @(negedge clk);
    port_en = 1;
    write(8'h96, 0); wait_idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule